// File: doc/BRIEF.md
# Ascending-Pattern Memory Sweep Tester

This block exercises an external byte-wide static memory through a plain request/done access port and reports whether every location stores and returns data correctly. A start strobe launches two sweeps. The first sweep stores a value derived from each address into every location, in ascending order. The second sweep reads the locations back, also in ascending order, and checks each byte against the value expected for that address.

Every location is filled before any location is read back. Between the store and the later read of one cell, the address and data lines have carried many other values. A data bus that is floating, or that only holds its last driven value, therefore cannot make a missing memory look good.

The sweep ends at the first wrong byte or after the last location. It then raises a done flag together with exactly one of pass or fail. On a failure it keeps the failing address and the byte that came back. Pin-level memory timing belongs to a separate access controller that sits behind the request/done port.

Top module: `sweep_tester`

## Requirements
- R1: After reset, `done_o`, `pass_o`, `fail_o`, `busy_o`, `mem_wr_o` and `mem_rd_o` are all 0.
- R2: A `start_i` pulse seen while idle clears done, pass, fail and the captured failure fields. On the next clock it raises `mem_wr_o` with `mem_addr_o` = 0 and `mem_wdata_o` = 0.
- R3: Writes cover the addresses 0, 1, ..., DEPTH-1 once each, in that order. All writes complete before the first read request.
- R4: The byte written to address n is n mod 256, which is the low 8 bits of n.
- R5: The block keeps a request (`mem_wr_o` or `mem_rd_o`) high, with a steady address, until `mem_done_i` is seen. The two requests are never high together. The address moves on only after a done.
- R6: Reads cover the addresses 0 to DEPTH-1 in ascending order. The byte on `mem_rdata_i` in the cycle of `mem_done_i` is compared with the address's low 8 bits.
- R7: At the first mismatch the block stops. It sets `done_o` and `fail_o`, stores the address in `fail_addr_o` and the byte read in `fail_data_o`, and issues no further request.
- R8: When all DEPTH reads match, the block sets `done_o` and `pass_o` and leaves `fail_o` low.
- R9: A `start_i` pulse during a sweep is ignored. The sweep completes with the same request count as an undisturbed one.
- R10: Done, pass, fail and the failure fields hold their values until the next accepted start. While `done_o` is 1, exactly one of `pass_o` and `fail_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle strobe that launches a test when idle |
| mem_done_i | input | 1 | One-cycle completion pulse from the access controller |
| mem_rdata_i | input | DATA_W | Read byte, valid in the cycle of `mem_done_i` |
| mem_addr_o | output | ADDR_W | Location of the current request |
| mem_wdata_o | output | DATA_W | Byte to store on a write request |
| mem_wr_o | output | 1 | Write request, held until done |
| mem_rd_o | output | 1 | Read request, held until done |
| busy_o | output | 1 | A sweep is running |
| done_o | output | 1 | Test finished |
| pass_o | output | 1 | Every location matched |
| fail_o | output | 1 | A mismatch was found |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| fail_data_o | output | DATA_W | Byte read at the first mismatch |

## Verification
Requests rise one clock after the edge that accepts a start or the previous done. The bench therefore checks the first write one negative edge after the start pulse. The memory model on the bench side answers each request after a random 0 to 3 idle cycles and checks the address, the data and the pass order at the moment it serves. Final status is registered on the edge that samples the last `mem_done_i`. The bench waits for `done_o` at negative edges instead of counting a fixed latency, and then checks the status, the captured fields and the request counts. Faults injected in the model give a first failing address and byte that follow directly from the requirements: a flipped cell, a stuck data bit, a tied address line and a bus that only holds its last value.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_ISSUE,
    ST_WR_WAIT,
    ST_RD_ISSUE,
    ST_RD_WAIT
  } sweep_state_t;
endpackage

// File: rtl/sweep_counter.sv
module sweep_counter #(
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] cnt,
  output logic              at_last
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  assign at_last = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc) begin
      // wrap to zero so the read sweep restarts at the bottom
      cnt <= at_last ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sweep_compare.sv
module sweep_compare #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] pattern,
  output logic              match
);
  generate
    if (DATA_W <= ADDR_W) begin : g_trunc
      assign pattern = addr[DATA_W-1:0];
    end else begin : g_extend
      assign pattern = {{(DATA_W-ADDR_W){1'b0}}, addr};
    end
  endgenerate

  assign match = (rdata == pattern);
endmodule

// File: rtl/sweep_fsm.sv
module sweep_fsm
  import sweep_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              mem_done_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [ADDR_W-1:0] cnt,
  input  logic              at_last,
  input  logic [DATA_W-1:0] pattern,
  input  logic              match,
  output logic              cnt_clr,
  output logic              cnt_inc,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_wr_o,
  output logic              mem_rd_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_data_o
);
  sweep_state_t state;

  assign busy_o  = (state != ST_IDLE);
  assign cnt_clr = (state == ST_IDLE) && start_i;
  assign cnt_inc = ((state == ST_WR_WAIT) || (state == ST_RD_WAIT)) && mem_done_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      mem_wr_o    <= 1'b0;
      mem_rd_o    <= 1'b0;
      done_o      <= 1'b0;
      pass_o      <= 1'b0;
      fail_o      <= 1'b0;
      fail_addr_o <= '0;
      fail_data_o <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            done_o      <= 1'b0;
            pass_o      <= 1'b0;
            fail_o      <= 1'b0;
            fail_addr_o <= '0;
            fail_data_o <= '0;
            mem_addr_o  <= '0;
            mem_wdata_o <= '0;
            mem_wr_o    <= 1'b1;
            state       <= ST_WR_WAIT;
          end
        end
        ST_WR_ISSUE: begin
          mem_addr_o  <= cnt;
          mem_wdata_o <= pattern;
          mem_wr_o    <= 1'b1;
          state       <= ST_WR_WAIT;
        end
        ST_WR_WAIT: begin
          if (mem_done_i) begin
            mem_wr_o <= 1'b0;
            state    <= at_last ? ST_RD_ISSUE : ST_WR_ISSUE;
          end
        end
        ST_RD_ISSUE: begin
          mem_addr_o <= cnt;
          mem_rd_o   <= 1'b1;
          state      <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (mem_done_i) begin
            mem_rd_o <= 1'b0;
            if (!match) begin
              fail_addr_o <= cnt;
              fail_data_o <= mem_rdata_i;
              fail_o      <= 1'b1;
              done_o      <= 1'b1;
              state       <= ST_IDLE;
            end else if (at_last) begin
              pass_o <= 1'b1;
              done_o <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              state <= ST_RD_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sweep_tester.sv
module sweep_tester #(
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 8192,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              mem_done_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_wr_o,
  output logic              mem_rd_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_data_o
);
  logic [ADDR_W-1:0] cnt;
  logic              at_last;
  logic              cnt_clr;
  logic              cnt_inc;
  logic [DATA_W-1:0] pattern;
  logic              match;

  sweep_counter #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
    .cnt(cnt), .at_last(at_last)
  );

  sweep_compare #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cmp (
    .addr(cnt), .rdata(mem_rdata_i), .pattern(pattern), .match(match)
  );

  sweep_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .mem_done_i(mem_done_i),
    .mem_rdata_i(mem_rdata_i), .cnt(cnt), .at_last(at_last),
    .pattern(pattern), .match(match), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_wr_o(mem_wr_o), .mem_rd_o(mem_rd_o), .busy_o(busy_o),
    .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o),
    .fail_addr_o(fail_addr_o), .fail_data_o(fail_data_o)
  );
endmodule

// File: rtl/sweep_tester_checker.sv
module sweep_tester_checker #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              mem_done_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_wr_o,
  input logic              mem_rd_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              fail_o
);
  logic read_phase;

  always_ff @(posedge clk) begin
    if (rst || (start_i && !busy_o)) read_phase <= 1'b0;
    else if (mem_rd_o)               read_phase <= 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !done_o && !busy_o && !mem_wr_o && !mem_rd_o);

  assert_start_first_write_R2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> mem_wr_o && mem_addr_o == '0 && !done_o && !fail_o && !pass_o);

  assert_no_write_after_read_R3: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> !read_phase);

  assert_write_pattern_R4: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> (mem_wdata_o[0] == mem_addr_o[0]));

  assert_single_request_R5: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr_o && mem_rd_o));

  assert_hold_request_R5: assert property (@(posedge clk) disable iff (rst)
    ((mem_wr_o || mem_rd_o) && !mem_done_i) |=>
      (mem_wr_o || mem_rd_o) && $stable(mem_addr_o));

  assert_idle_when_done_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !mem_wr_o && !mem_rd_o);

  assert_one_verdict_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (pass_o != fail_o));

  assert_verdict_needs_done_R10: assert property (@(posedge clk) disable iff (rst)
    (pass_o || fail_o) |-> done_o);
endmodule

bind sweep_tester sweep_tester_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .mem_done_i(mem_done_i),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_wr_o(mem_wr_o),
  .mem_rd_o(mem_rd_o), .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o),
  .fail_o(fail_o)
);

// File: tb/test_sweep_tester.sv
module test_sweep_tester;
  localparam int AW = 9;
  localparam int DP = 300;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mem_done = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_wr, mem_rd, busy, done, pass, fail;
  logic [AW-1:0] fail_addr;
  logic [DW-1:0] fail_data;

  always #10 clk = ~clk;

  sweep_tester #(.ADDR_W(AW), .DEPTH(DP), .DATA_W(DW)) i_sweep_tester (
    .clk(clk), .rst(rst), .start_i(start), .mem_done_i(mem_done),
    .mem_rdata_i(mem_rdata), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_wr_o(mem_wr), .mem_rd_o(mem_rd), .busy_o(busy), .done_o(done),
    .pass_o(pass), .fail_o(fail), .fail_addr_o(fail_addr), .fail_data_o(fail_data)
  );

  int checks = 0;
  int errors = 0;

  // memory model state
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [DW-1:0] bus_last = '0;
  int fault_mode = 0;   // 0 none, 1 flip cell, 2 stuck-0 data bit, 3 tied address bit, 4 holding bus
  int fault_addr = 0;
  int fault_arg  = 0;
  int lat_left   = -1;
  int exp_wr = 0, exp_rd = 0, wr_cnt = 0, rd_cnt = 0, proto_bad = 0;
  bit read_seen = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int map_addr(input int a);
    if (fault_mode == 3) return a & ~(1 << fault_arg);
    return a;
  endfunction

  task automatic serve();
    int a;
    a = map_addr(int'(mem_addr));
    if (mem_wr) begin
      if (int'(mem_addr) != exp_wr || read_seen || int'(mem_wdata) != (int'(mem_addr) % 256))
        proto_bad++;
      exp_wr++;
      wr_cnt++;
      mem[a]   = (fault_mode == 2) ? (mem_wdata & ~DW'(1 << fault_arg)) : mem_wdata;
      bus_last = mem_wdata;
    end else begin
      read_seen = 1;
      if (int'(mem_addr) != exp_rd) proto_bad++;
      exp_rd++;
      rd_cnt++;
      if (fault_mode == 4)
        mem_rdata = bus_last;
      else if (fault_mode == 1 && int'(mem_addr) == fault_addr)
        mem_rdata = mem[a] ^ DW'(fault_arg);
      else
        mem_rdata = mem[a];
      bus_last = mem_rdata;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      mem_done = 1'b0;
      if (!rst && (mem_wr || mem_rd)) begin
        if (lat_left < 0) lat_left = int'($urandom_range(0, 3));
        if (lat_left == 0) begin
          serve();
          mem_done = 1'b1;
          lat_left = -1;
        end else begin
          lat_left--;
        end
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // launch a test and check R2 one cycle after the accepting edge
  task automatic launch();
    exp_wr = 0; exp_rd = 0; wr_cnt = 0; rd_cnt = 0; proto_bad = 0; read_seen = 0;
    pulse_start();
    check(mem_wr && mem_addr == '0 && mem_wdata == '0, "R2 first write",
          int'(mem_addr), 0);
    check(!done && !pass && !fail && fail_addr == '0, "R2 status cleared",
          int'({done, pass, fail}), 0);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic expect_pass(input string tag);
    wait_done();
    check(done && pass && !fail, {tag, " R8 pass verdict"}, int'({done, pass, fail}), 6);
    check(wr_cnt == DP && rd_cnt == DP, {tag, " R3 R6 full sweeps"}, wr_cnt + rd_cnt, 2 * DP);
    check(proto_bad == 0, {tag, " R3 R4 R6 order and data"}, proto_bad, 0);
  endtask

  task automatic expect_fail(input string tag, input int fa, input int fd);
    wait_done();
    check(done && fail && !pass, {tag, " R7 fail verdict"}, int'({done, pass, fail}), 5);
    check(int'(fail_addr) == fa, {tag, " R7 fail address"}, int'(fail_addr), fa);
    check(int'(fail_data) == fd, {tag, " R7 fail data"}, int'(fail_data), fd);
    check(rd_cnt == fa + 1 && wr_cnt == DP, {tag, " R7 stop at first mismatch"}, rd_cnt, fa + 1);
    repeat (6) @(negedge clk);
    check(!mem_wr && !mem_rd && rd_cnt == fa + 1, {tag, " R7 no requests after stop"},
          rd_cnt, fa + 1);
    check(done && fail && int'(fail_addr) == fa, {tag, " R10 status held"},
          int'(fail_addr), fa);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!done && !pass && !fail && !busy && !mem_wr && !mem_rd, "R1 reset state",
          int'({done, pass, fail, busy, mem_wr, mem_rd}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !mem_wr, "R1 idle without start", int'(busy), 0);

    // clean memory, pattern wraps past 256 (R4)
    fault_mode = 0;
    launch();
    expect_pass("clean");

    // flipped cell at random addresses, including the boundaries
    for (int k = 0; k < 5; k++) begin
      int fa, m;
      fa = (k == 0) ? 0 : (k == 1) ? DP - 1 : int'($urandom_range(1, DP - 2));
      m  = int'($urandom_range(1, 255));
      fault_mode = 1; fault_addr = fa; fault_arg = m;
      launch();
      expect_fail("flip", fa, (fa % 256) ^ m);
    end

    // stuck-at-0 data bit: first address with that bit set
    begin
      int b;
      b = int'($urandom_range(0, 7));
      fault_mode = 2; fault_arg = b;
      launch();
      expect_fail("stuck bit", 1 << b, 0);
    end

    // tied low address bit: address 0 holds the aliased later write
    begin
      int b;
      b = int'($urandom_range(0, 7));
      fault_mode = 3; fault_arg = b;
      launch();
      expect_fail("tied addr", 0, (1 << b) % 256);
    end

    // bus that keeps its last value: stale top byte seen at address 0
    fault_mode = 4;
    launch();
    expect_fail("holding bus", 0, (DP - 1) % 256);

    // restart after a failure, with a start pulse in mid-sweep (R9)
    fault_mode = 0;
    launch();
    repeat (40) @(negedge clk);
    check(busy, "R9 busy mid-sweep", int'(busy), 1);
    pulse_start();
    expect_pass("restart");
    check(wr_cnt + rd_cnt == 2 * DP, "R9 extra start ignored", wr_cnt + rd_cnt, 2 * DP);
    repeat (5) @(negedge clk);
    check(done && pass && !mem_wr && !mem_rd, "R10 pass held", int'({done, pass}), 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule